// File: doc/BRIEF.md
# Atomic Load-and-Operate Memory Unit

This unit executes a small family of 32-bit read-modify-write instructions against an internal memory organised as 64-bit rows. Each instruction names a location through a base-register value. The unit reads a word (4 bytes) or a doubleword (8 bytes) there and combines it with an operand. The operand is a hardwired constant (+1, all ones, zero) or a register value. The unit writes the result back and returns the previous contents, sign-extended to 64 bits for word forms, together with the destination register index.

There are two families of operation. The fetch-and-add family covers increment, decrement and add-register. The exchange family covers set, clear and swap-register. In both, the returned value is the memory contents before the update.

A start strobe hands over the instruction word, the base value, the add-register value and a byte-order select. While the unit is busy it accepts nothing else, so the read and the write of one request are never split by another access. Bad encodings and misaligned addresses raise a fault flag and leave memory untouched.

Top module: `amo_unit`

## Requirements
- R1: An instruction is legal only if bits [31:26] = 011100, bits [5:0] = 011111, and bits [10:6] are one of the following subfunctions:
  - 00010 / 00011: increment word / doubleword
  - 00110 / 00111: decrement word / doubleword
  - 10010 / 10011: add-register word / doubleword
  - 01010 / 01011: set word / doubleword
  - 01110 / 01111: clear word / doubleword
  - 10110 / 10111: swap word / doubleword

  Any other instruction gives `fault_illegal`=1, `old_val`=0 and `dest_we`=0, and leaves memory unchanged.
- R2: For the increment, decrement, set and clear forms, bits [20:16] must be 00000. A nonzero value is treated as illegal, exactly as in R1.
- R3: Increment adds +1, decrement adds -1 and add-register adds `add_val`, all modulo the access width. Memory receives the sum and `old_val` returns the prior contents.
- R4: Set stores all ones, clear stores zero and swap stores `add_val`. `old_val` returns the prior contents.
- R5: Word forms use only `add_val[31:0]` and change only the 4 addressed bytes. They return the old 32-bit value sign-extended to 64 bits.
- R6: Bit 6 of the instruction selects the size: 1 = doubleword, 0 = word.
- R7: The byte address is `base_val` with no offset. Only its low 9 bits (64 rows of 8 bytes) select the location; higher bits are ignored.
- R8: A word whose address has bits [1:0] ≠ 0, or a doubleword whose address has bits [2:0] ≠ 0, gives `fault_align`=1, `old_val`=0 and `dest_we`=0, and leaves memory unchanged. An illegal encoding reports only `fault_illegal`.
- R9: `big_endian`, sampled with `start`, sets the byte order. With `big_endian`=1 the byte at the lowest address is the most significant; with 0 it is the least significant.
- R10: `start` is accepted on a clock edge only while `busy`=0. `busy` is 1 for the two cycles after acceptance. `done` is a one-cycle pulse in the third cycle. A `start` seen while `busy`=1 is ignored.
- R11: After reset, `busy`, `done`, `dest_we`, `fault_align`, `fault_illegal` and `old_val` are all 0.
- R12: With each `done`, `dest_idx` reports instruction bits [15:11]. `dest_we`=1 exactly when neither fault flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe |
| insn | input | 32 | Instruction word |
| base_val | input | 64 | Base register value (byte address) |
| add_val | input | 64 | Add/swap register value |
| big_endian | input | 1 | Byte order select |
| busy | output | 1 | Request in progress |
| done | output | 1 | Result valid pulse |
| old_val | output | 64 | Prior memory value, sign-extended for words |
| dest_idx | output | 5 | Destination register index |
| dest_we | output | 1 | Destination write enable |
| fault_align | output | 1 | Misaligned access |
| fault_illegal | output | 1 | Illegal encoding |

## Verification
Results are due on a fixed schedule. When a start is accepted on edge E0, `busy` is high after E0 and E1, and the read row is captured at E1. The write-back and the registered `done`, `old_val`, `dest_idx` and fault flags all land at E2, and `done` drops again at E3. The bench model counts these edges itself and compares `busy` and `done` on every falling edge, along with the result fields whenever a pulse is expected. Memory effects are checked only through later operations, whose returned old values must match the bench's byte-level memory image.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int DATA_W = 64;
  localparam int HALF_W = DATA_W / 2;

  typedef enum logic [1:0] {
    SRC_PLUS1,
    SRC_ONES,
    SRC_ZERO,
    SRC_REG
  } amo_src_e;

  typedef enum logic {
    KIND_ADD,
    KIND_XCHG
  } amo_kind_e;

  typedef struct packed {
    logic      legal;
    logic      dw;
    amo_kind_e kind;
    amo_src_e  src;
    logic [4:0] rd;
  } amo_dec_t;

  function automatic logic [HALF_W-1:0] swap_bytes32(input logic [HALF_W-1:0] v);
    logic [HALF_W-1:0] r;
    for (int i = 0; i < HALF_W / 8; i++)
      r[8*i +: 8] = v[HALF_W - 8*(i+1) +: 8];
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] swap_bytes64(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W / 8; i++)
      r[8*i +: 8] = v[DATA_W - 8*(i+1) +: 8];
    return r;
  endfunction
endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
(
  input  logic [31:0] insn,
  output amo_dec_t    dec
);
  localparam logic [5:0] MAJOR = 6'b011100;
  localparam logic [5:0] MINOR = 6'b011111;

  logic       frame_ok;
  logic       imm_clean;
  logic       sub_ok;
  logic [4:0] sub;

  assign sub       = insn[10:6];
  assign frame_ok  = (insn[31:26] == MAJOR) && (insn[5:0] == MINOR);
  assign imm_clean = (insn[20:16] == 5'd0);

  always_comb begin
    sub_ok   = 1'b1;
    dec.kind = KIND_ADD;
    dec.src  = SRC_PLUS1;
    unique case (sub[4:1])
      4'b0001: begin dec.kind = KIND_ADD;  dec.src = SRC_PLUS1; sub_ok = imm_clean; end
      4'b0011: begin dec.kind = KIND_ADD;  dec.src = SRC_ONES;  sub_ok = imm_clean; end
      4'b1001: begin dec.kind = KIND_ADD;  dec.src = SRC_REG;  end
      4'b0101: begin dec.kind = KIND_XCHG; dec.src = SRC_ONES;  sub_ok = imm_clean; end
      4'b0111: begin dec.kind = KIND_XCHG; dec.src = SRC_ZERO;  sub_ok = imm_clean; end
      4'b1011: begin dec.kind = KIND_XCHG; dec.src = SRC_REG;  end
      default: sub_ok = 1'b0;
    endcase
    dec.legal = frame_ok && sub_ok;
    dec.dw    = sub[0];
    dec.rd    = insn[15:11];
  end
endmodule

// File: rtl/amo_ram.sv
module amo_ram #(
  parameter int ROWS   = 64,
  parameter int DATA_W = 64,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              re,
  input  logic [ROW_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic              we,
  input  logic [ROW_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata
);
  logic [DATA_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/amo_lane.sv
module amo_lane
  import amo_pkg::*;
(
  input  logic              dw,
  input  logic              be,
  input  logic              hi,
  input  amo_kind_e         kind,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] row,
  output logic [DATA_W-1:0] old_ext,
  output logic [DATA_W-1:0] new_row
);
  logic [HALF_W-1:0] w_slice, w_old, w_new, w_store;
  logic [DATA_W-1:0] d_old, d_new;

  always_comb begin
    w_slice = hi ? row[DATA_W-1:HALF_W] : row[HALF_W-1:0];
    w_old   = be ? swap_bytes32(w_slice) : w_slice;
    d_old   = be ? swap_bytes64(row) : row;

    w_new = (kind == KIND_ADD) ? (w_old + operand[HALF_W-1:0]) : operand[HALF_W-1:0];
    d_new = (kind == KIND_ADD) ? (d_old + operand) : operand;

    w_store = be ? swap_bytes32(w_new) : w_new;

    if (dw)
      new_row = be ? swap_bytes64(d_new) : d_new;
    else if (hi)
      new_row = {w_store, row[HALF_W-1:0]};
    else
      new_row = {row[DATA_W-1:HALF_W], w_store};

    old_ext = dw ? d_old : {{HALF_W{w_old[HALF_W-1]}}, w_old};
  end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int ROWS = 64,
  localparam int ROW_W = $clog2(ROWS),
  localparam int BYTE_ADDR_W = ROW_W + 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] insn,
  input  logic [63:0] base_val,
  input  logic [63:0] add_val,
  input  logic        big_endian,
  output logic        busy,
  output logic        done,
  output logic [63:0] old_val,
  output logic [4:0]  dest_idx,
  output logic        dest_we,
  output logic        fault_align,
  output logic        fault_illegal
);
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} state_e;

  state_e            state;
  amo_dec_t          dec, q_dec;
  logic [ROW_W-1:0]  q_row;
  logic              q_hi, q_be, q_ill, q_mis;
  logic [DATA_W-1:0] q_opnd, opnd, rdata, old_ext, new_row;
  logic              accept, misalign, q_ok;

  amo_decode u_dec (.insn(insn), .dec(dec));

  assign accept   = start && (state == ST_IDLE);
  assign misalign = dec.dw ? (base_val[2:0] != 3'd0) : (base_val[1:0] != 2'd0);
  assign q_ok     = !q_ill && !q_mis;
  assign busy     = (state != ST_IDLE);

  always_comb begin
    unique case (dec.src)
      SRC_PLUS1: opnd = 64'd1;
      SRC_ONES:  opnd = '1;
      SRC_ZERO:  opnd = '0;
      default:   opnd = add_val;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      q_dec  <= '0;
      q_row  <= '0;
      q_hi   <= 1'b0;
      q_be   <= 1'b0;
      q_ill  <= 1'b0;
      q_mis  <= 1'b0;
      q_opnd <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state  <= ST_RD;
          q_dec  <= dec;
          q_row  <= base_val[BYTE_ADDR_W-1:3];
          q_hi   <= base_val[2];
          q_be   <= big_endian;
          q_ill  <= !dec.legal;
          q_mis  <= dec.legal && misalign;
          q_opnd <= opnd;
        end
        ST_RD:   state <= ST_WR;
        default: state <= ST_IDLE;
      endcase
    end
  end

  amo_ram #(.ROWS(ROWS), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .re    ((state == ST_RD) && q_ok),
    .raddr (q_row),
    .rdata (rdata),
    .we    ((state == ST_WR) && q_ok),
    .waddr (q_row),
    .wdata (new_row)
  );

  amo_lane u_lane (
    .dw      (q_dec.dw),
    .be      (q_be),
    .hi      (q_hi),
    .kind    (q_dec.kind),
    .operand (q_opnd),
    .row     (rdata),
    .old_ext (old_ext),
    .new_row (new_row)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done          <= 1'b0;
      dest_we       <= 1'b0;
      old_val       <= '0;
      dest_idx      <= '0;
      fault_align   <= 1'b0;
      fault_illegal <= 1'b0;
    end else if (state == ST_WR) begin
      done          <= 1'b1;
      dest_we       <= q_ok;
      old_val       <= q_ok ? old_ext : '0;
      dest_idx      <= q_dec.rd;
      fault_align   <= q_mis;
      fault_illegal <= q_ill;
    end else begin
      done    <= 1'b0;
      dest_we <= 1'b0;
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R10
  done_latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start && !busy, 3));
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy);
  // R12
  dest_we_chk: assert property (@(posedge clk) disable iff (rst)
    dest_we |-> (done && !fault_align && !fault_illegal));
  // R8
  fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fault_align, fault_illegal}));
  // R8
  no_fault_write_chk: assert property (@(posedge clk) disable iff (rst)
    (done && (fault_align || fault_illegal)) |-> (old_val == 64'd0));
  // R5
  word_sext_chk: assert property (@(posedge clk) disable iff (rst)
    (dest_we && !q_dec.dw) |-> (old_val[63:32] == {32{old_val[31]}}));
endmodule

// File: tb/sim_amo_unit.sv
module sim_amo_unit;
  localparam int MEM_BYTES = 512;
  localparam logic [4:0] S_INCW = 5'b00010, S_INCD = 5'b00011;
  localparam logic [4:0] S_DECW = 5'b00110, S_DECD = 5'b00111;
  localparam logic [4:0] S_ADDW = 5'b10010, S_ADDD = 5'b10011;
  localparam logic [4:0] S_SETW = 5'b01010, S_SETD = 5'b01011;
  localparam logic [4:0] S_CLRW = 5'b01110, S_CLRD = 5'b01111;
  localparam logic [4:0] S_SWPW = 5'b10110, S_SWPD = 5'b10111;

  logic clk = 0, rst = 1, start = 0, big_endian = 0;
  logic [31:0] insn = '0;
  logic [63:0] base_val = '0, add_val = '0;
  logic busy, done, dest_we, fault_align, fault_illegal;
  logic [63:0] old_val;
  logic [4:0]  dest_idx;

  always #10 clk = ~clk;

  amo_unit u0 (.*);

  int tests = 0, fails = 0, cycles = 0;
  string cur_tag = "R3";

  logic [7:0] mb [MEM_BYTES];
  bit         kn [MEM_BYTES];
  int         cnt = 0;
  logic [63:0] e_old;
  logic [4:0]  e_rd;
  bit e_we, e_fa, e_fi, e_known;
  string e_tag;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_accept();
    logic [4:0] sub = insn[10:6];
    bit legal, dw, imm, isadd;
    int a, nb;
    logic [63:0] v, opv, nv;
    legal = (insn[31:26] == 6'b011100) && (insn[5:0] == 6'b011111);
    imm = (sub inside {S_INCW, S_INCD, S_DECW, S_DECD, S_SETW, S_SETD, S_CLRW, S_CLRD});
    if (!(imm || sub inside {S_ADDW, S_ADDD, S_SWPW, S_SWPD})) legal = 0;
    if (imm && insn[20:16] != 0) legal = 0;
    dw = sub[0];
    nb = dw ? 8 : 4;
    a  = int'(base_val[8:0]);
    e_rd = insn[15:11]; e_tag = cur_tag; e_fi = !legal;
    e_fa = legal && (a % nb != 0);
    e_we = legal && !e_fa; e_old = 0; e_known = 1;
    if (!e_we) return;
    v = 0;
    for (int i = 0; i < nb; i++) begin
      if (!kn[a+i]) e_known = 0;
      if (big_endian) v = {v[55:0], mb[a+i]};
      else v[8*i +: 8] = mb[a+i];
    end
    case (sub[4:1])
      4'b0001: begin isadd = 1; opv = 1; end
      4'b0011: begin isadd = 1; opv = '1; end
      4'b1001: begin isadd = 1; opv = add_val; end
      4'b0101: begin isadd = 0; opv = '1; end
      4'b0111: begin isadd = 0; opv = 0; end
      default: begin isadd = 0; opv = add_val; end
    endcase
    nv = isadd ? v + opv : opv;
    if (!dw) nv[63:32] = 0;
    for (int i = 0; i < nb; i++) begin
      mb[a+i] = big_endian ? 8'(nv >> (8*(nb-1-i))) : 8'(nv >> (8*i));
      kn[a+i] = 1;
    end
    e_old = dw ? v : {{32{v[31]}}, v[31:0]};
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) cnt = 0;
    else if (start && cnt <= 1) begin model_accept(); cnt = 3; end
    else if (cnt > 0) cnt--;
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(busy == (cnt >= 2), "R10", "busy", 64'(busy), 64'(cnt >= 2));
      check(done == (cnt == 1), "R10", "done", 64'(done), 64'(cnt == 1));
      if (cnt == 1 && done) begin
        if (e_known) check(old_val == e_old, e_tag, "old_val", old_val, e_old);
        check(dest_idx == e_rd, "R12", "dest_idx", 64'(dest_idx), 64'(e_rd));
        check(dest_we == e_we, e_tag, "dest_we", 64'(dest_we), 64'(e_we));
        check(fault_align == e_fa, e_tag, "fault_align", 64'(fault_align), 64'(e_fa));
        check(fault_illegal == e_fi, e_tag, "fault_illegal", 64'(fault_illegal), 64'(e_fi));
      end
    end
  end

  function automatic logic [31:0] mk(input logic [4:0] sub, input logic [4:0] af,
                                     input logic [4:0] rd);
    return {6'b011100, 5'd3, af, rd, sub, 6'b011111};
  endfunction

  task automatic op_raw(input logic [31:0] w, input logic [63:0] b, input logic [63:0] av,
                        input bit be, input string tag);
    @(negedge clk);
    insn = w; base_val = b; add_val = av; big_endian = be; cur_tag = tag; start = 1;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic op(input logic [4:0] sub, input logic [4:0] rd, input logic [63:0] b,
                    input logic [63:0] av, input bit be, input string tag);
    op_raw(mk(sub, (sub[4] ? 5'd7 : 5'd0), rd), b, av, be, tag);
  endtask

  initial begin
    for (int i = 0; i < MEM_BYTES; i++) begin mb[i] = 0; kn[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    check(!busy && !done && !dest_we && !fault_align && !fault_illegal && old_val == 0,
          "R11", "reset outputs", {busy, done, dest_we, fault_align, fault_illegal}, 64'd0);
    for (int r = 0; r < 8; r++)
      op(S_SWPD, 5'(r+1), 64'(r*8), 64'h1111_2222_3333_4444 * 64'(r+1), 0, "R4");
    op(S_INCW, 5'd2, 64'd0, 64'hDEAD, 0, "R3");
    op(S_INCD, 5'd4, 64'd8, 64'd0, 0, "R6");
    op(S_DECW, 5'd5, 64'd4, 64'd0, 0, "R3");
    op(S_ADDD, 5'd6, 64'd8, 64'hF000_0000_0000_0005, 0, "R3");
    op(S_ADDW, 5'd7, 64'd0, 64'hFFFF_FFFF_0000_0010, 0, "R5");
    op(S_ADDD, 5'd8, 64'd0, 64'd0, 0, "R5");
    op(S_SETW, 5'd9, 64'd16, 64'd0, 0, "R4");
    op(S_CLRD, 5'd10, 64'd24, 64'd0, 0, "R4");
    op(S_SWPW, 5'd11, 64'd28, 64'h1234_5678_8765_4321, 0, "R4");
    op(S_ADDD, 5'd12, 64'd16, 64'd0, 0, "R4");
    op(S_ADDD, 5'd13, 64'd24, 64'd0, 0, "R5");
    op(S_SETD, 5'd14, 64'd48, 64'd0, 0, "R4");
    op(S_CLRW, 5'd15, 64'd52, 64'd0, 0, "R4");
    op(S_DECD, 5'd16, 64'd48, 64'd0, 0, "R3");
    op(S_SWPW, 5'd17, 64'd32, 64'h8000_0000, 0, "R5");
    op(S_INCW, 5'd18, 64'd32, 64'd0, 0, "R5");
    op(S_CLRW, 5'd19, 64'd36, 64'd0, 0, "R3");
    op(S_DECW, 5'd20, 64'd36, 64'd0, 0, "R3");
    op(S_INCW, 5'd21, 64'd36, 64'd0, 0, "R3");
    op(S_SWPD, 5'd22, 64'd40, 64'h0102_0304_0506_0708, 1, "R9");
    op(S_INCW, 5'd23, 64'd40, 64'd0, 1, "R9");
    op(S_INCW, 5'd24, 64'd44, 64'd0, 0, "R9");
    op(S_ADDD, 5'd25, 64'd40, 64'd0, 0, "R9");
    op(S_ADDD, 5'd26, 64'd40, 64'd0, 1, "R9");
    op(S_INCD, 5'd27, 64'hFFFF_0000_0000_0208, 64'd0, 0, "R7");
    op(S_ADDD, 5'd28, 64'd8, 64'd0, 0, "R7");
    op(S_INCW, 5'd29, 64'd2, 64'd0, 0, "R8");
    op(S_INCD, 5'd30, 64'd4, 64'd0, 0, "R8");
    op(S_SWPW, 5'd31, 64'd1, 64'hAA, 0, "R8");
    op(S_ADDD, 5'd1, 64'd0, 64'd0, 0, "R8");
    op_raw(mk(5'b00000, 5'd0, 5'd3), 64'd0, 64'd0, 0, "R1");
    op_raw(mk(5'b11010, 5'd0, 5'd3), 64'd0, 64'd0, 0, "R1");
    op_raw({6'b011101, 5'd3, 5'd0, 5'd4, S_INCW, 6'b011111}, 64'd0, 64'd0, 0, "R1");
    op_raw({6'b011100, 5'd3, 5'd0, 5'd4, S_INCW, 6'b011110}, 64'd0, 64'd0, 0, "R1");
    op_raw(mk(S_INCW, 5'd9, 5'd6), 64'd0, 64'd0, 0, "R2");
    op_raw(mk(S_CLRD, 5'd1, 5'd6), 64'd0, 64'd0, 0, "R2");
    op_raw(mk(S_INCW, 5'd9, 5'd6), 64'd3, 64'd0, 0, "R8");
    op(S_ADDD, 5'd2, 64'd0, 64'd0, 0, "R2");
    // R10: start held through busy; only the idle-time edges accept
    @(negedge clk);
    insn = mk(S_INCD, 5'd0, 5'd9); base_val = 64'd56; add_val = 0; cur_tag = "R10"; start = 1;
    repeat (4) @(negedge clk);
    start = 0;
    repeat (4) @(negedge clk);
    op(S_ADDD, 5'd3, 64'd56, 64'd0, 0, "R10");
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule